// File: doc/BRIEF.md
# Serial Boot Command Parser

This block sits between a UART receiver and transmitter and interprets the ASCII command stream a host sends to bring up a device over a serial line. It recognizes three eight-character keywords: an identity query (`Boot_Qry`) and two program loads, one with payload bytes written as hexadecimal tokens (`Boot_Hex`) and one with payload written in Base64 (`Boot_B64`). Each keyword is followed by four hexadecimal arguments that form two mask/value pairs. The command is obeyed only when the two device input-pin buses, masked, equal the given values. This lets many devices share one serial line and answer selectively.

Payload bytes leave on a simple write port at consecutive addresses from zero. The character that closes a load chooses what happens next. `~` starts execution at once. `?` first checks that the payload bytes sum to zero modulo 256, then replies `.` and starts execution, or replies `!` and waits for a new command. A `>` byte, which the host also sends for baud measurement, puts the parser back into keyword search at any time.

Top module: `boot_cmd_parser`

## Requirements
- R1: After synchronous active-low reset, rx_ready is 1 and tx_valid, wr_en and run are 0.
- R2: Keyword search accepts `Boot_Qry`, `Boot_Hex` and `Boot_B64`. A mismatching `B` restarts the match. A received `>` (0x3E), in any state except while a reply is pending, abandons the current command and returns to keyword search.
- R3: After the keyword come four hex arguments (mask A, value A, mask B, value B), each ended by space, CR or LF. If (pins_a & mask A) != value A or (pins_b & mask B) != value B, the command has no effect: no reply, no write and no run.
- R4: A qualified identity query replies with the six bytes `SBC1` CR LF (0x53 0x42 0x43 0x31 0x0D 0x0A).
- R5: In a hex load, each token of hex digits closed by a separator or terminator writes its low 8 bits. Writes go to consecutive addresses starting at 0 for every load.
- R6: In a Base64 load, the characters A–Z, a–z, 0–9, `+` and `/` carry the values 0–63 and are packed most significant bit first. Each completed 8 bits are written. `=` and separators are skipped. Leftover bits are dropped at the terminator.
- R7: A load closed by `~` (0x7E) sends no reply and pulses run after the last write.
- R8: A load closed by `?` (0x3F) whose payload bytes sum to 0 mod 256 replies `.` (0x2E) and then pulses run.
- R9: A load closed by `?` whose sum is nonzero replies `!` (0x21), does not pulse run and returns to keyword search.
- R10: A character that is not legal where it arrives, in arguments or payload, aborts the command with no reply and no run.
- R11: While a reply is pending, rx_ready is 0. tx_data stays stable while tx_valid is high and tx_ready is low.
- R12: run is high for exactly one cycle per started execution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Parser accepts a byte this cycle |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter takes the reply byte |
| pins_a | input | PIN_W | First input-pin bus for qualification |
| pins_b | input | PIN_W | Second input-pin bus for qualification |
| wr_en | output | 1 | Payload byte write strobe |
| wr_addr | output | ADDR_W | Payload write address |
| wr_data | output | 8 | Payload byte |
| run | output | 1 | One-cycle start-execution pulse |

## Verification
The loads are driven with hex tokens of one, two and three digits, which shows whether only the low byte is kept and whether the address restarts. Base64 runs use full quads, quads split by spaces and padding, and all-zero data, which separates bit packing from leftover handling and gives a passing checksum. Pass and fail of the pin masks on both buses, illegal characters in arguments and in payload, a `>` in the middle of a command and a doubled leading `B` tell qualification, abort and resynchronisation apart. A held-off transmitter shows that input stalls and the reply byte stays put.

// File: rtl/boot_cmd_pkg.sv
// Shared constants, enums and character helpers for the serial boot parser.
// Assumes 8-bit ASCII input.
package boot_cmd_pkg;

    localparam int N_CMD   = 3;
    localparam int KEY_LEN = 8;
    localparam int ID_LEN  = 6;

    localparam logic [7:0] CH_SYNC    = 8'h3E;
    localparam logic [7:0] CH_CHECKED = 8'h3F;
    localparam logic [7:0] CH_DIRECT  = 8'h7E;
    localparam logic [7:0] CH_PAD     = 8'h3D;
    localparam logic [7:0] CH_PASS    = 8'h2E;
    localparam logic [7:0] CH_FAIL    = 8'h21;

    typedef enum logic [1:0] {CMD_QRY = 2'd0, CMD_HEX = 2'd1, CMD_B64 = 2'd2} cmd_e;
    typedef enum logic [1:0] {REP_ID = 2'd0, REP_PASS = 2'd1, REP_FAIL = 2'd2} rep_e;

    // Character idx of keyword number cmd
    function automatic logic [7:0] key_char(input int cmd, input logic [2:0] idx);
        logic [63:0] w;
        case (cmd)
            0:       w = "Boot_Qry";
            1:       w = "Boot_Hex";
            default: w = "Boot_B64";
        endcase
        return w[8*(7-int'(idx)) +: 8];
    endfunction

    // Character idx of the identity reply
    function automatic logic [7:0] id_char(input logic [2:0] idx);
        logic [47:0] s;
        s = {"SBC1", 8'h0D, 8'h0A};
        return s[8*(5-int'(idx)) +: 8];
    endfunction

    function automatic logic is_sep(input logic [7:0] c);
        return (c == 8'h20) || (c == 8'h0D) || (c == 8'h0A);
    endfunction

    function automatic logic is_hex(input logic [7:0] c);
        return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46) ||
               (c >= 8'h61 && c <= 8'h66);
    endfunction

    function automatic logic [3:0] hex_val(input logic [7:0] c);
        logic [7:0] t;
        if (c <= 8'h39)      t = c - 8'h30;
        else if (c <= 8'h46) t = c - 8'h41 + 8'd10;
        else                 t = c - 8'h61 + 8'd10;
        return t[3:0];
    endfunction

    function automatic logic is_b64(input logic [7:0] c);
        return (c >= 8'h41 && c <= 8'h5A) || (c >= 8'h61 && c <= 8'h7A) ||
               (c >= 8'h30 && c <= 8'h39) || (c == 8'h2B) || (c == 8'h2F);
    endfunction

    function automatic logic [5:0] b64_val(input logic [7:0] c);
        logic [7:0] t;
        if (c >= 8'h41 && c <= 8'h5A)      t = c - 8'h41;
        else if (c >= 8'h61 && c <= 8'h7A) t = c - 8'h61 + 8'd26;
        else if (c >= 8'h30 && c <= 8'h39) t = c - 8'h30 + 8'd52;
        else if (c == 8'h2B)               t = 8'd62;
        else                               t = 8'd63;
        return t[5:0];
    endfunction

endpackage

// File: rtl/boot_key_match.sv
// Keyword matcher: tracks all keywords in parallel, one character per strobe.
// hit is combinational on the strobe that completes a keyword; cmd names it.
// Assumes every keyword has the same length and first character.
module boot_key_match
    import boot_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       stb,
    input  logic [7:0] ch,
    output logic       hit,
    output cmd_e       cmd
);
    localparam logic [2:0] LAST = 3'(KEY_LEN - 1);

    logic [2:0]       idx;
    logic [N_CMD-1:0] cand, m, cand_nx, base;
    logic             first;

    // Per-keyword compare of the current character
    for (genvar g = 0; g < N_CMD; g++) begin : g_cmp
        assign m[g] = (ch == key_char(g, idx));
    end

    assign first   = (ch == key_char(0, 3'd0));
    assign base    = (idx == 3'd0) ? '1 : cand;
    assign cand_nx = base & m;
    assign hit     = stb && (idx == LAST) && (|cand_nx);

    // Name the keyword that survives to the last character
    always_comb begin
        if (cand_nx[2])      cmd = CMD_B64;
        else if (cand_nx[1]) cmd = CMD_HEX;
        else                 cmd = CMD_QRY;
    end

    // Advance, restart or clear the match position
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx  <= 3'd0;
            cand <= '0;
        end else if (stb) begin
            if (hit) begin
                idx <= 3'd0;
            end else if (|cand_nx) begin
                idx  <= idx + 3'd1;
                cand <= cand_nx;
            end else if (first) begin
                idx  <= 3'd1;
                cand <= '1;
            end else begin
                idx <= 3'd0;
            end
        end
    end
endmodule

// File: rtl/boot_payload.sv
// Payload decoder: turns hex tokens or Base64 characters into byte writes at
// consecutive addresses, keeping a running 8-bit sum. sum_after includes a hex
// token still open when the terminator arrives. Assumes the caller strobes only
// characters that are legal (bad = 0) and flags the terminator with flush.
module boot_payload
    import boot_cmd_pkg::*;
#(
    parameter int ADDR_W = 10
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              stb,
    input  logic              flush,
    input  logic              b64,
    input  logic [7:0]        ch,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [7:0]        sum_after,
    output logic              bad
);
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        sum, tok;
    logic              has;
    logic [11:0]       acc, acc_nx;
    logic [2:0]        bcnt;
    logic [3:0]        c;
    logic [11:0]       shifted;

    assign acc_nx    = {acc[5:0], b64_val(ch)};
    assign c         = {1'b0, bcnt} + 4'd6;
    assign shifted   = acc_nx >> (c - 4'd8);
    assign sum_after = sum + ((!b64 && has) ? tok : 8'h00);
    assign bad       = b64 ? !(is_b64(ch) || is_sep(ch) || ch == CH_PAD)
                           : !(is_hex(ch) || is_sep(ch));

    // Assemble bytes and issue writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= 8'h00;
            ptr     <= '0;
            sum     <= 8'h00;
            tok     <= 8'h00;
            has     <= 1'b0;
            acc     <= '0;
            bcnt    <= 3'd0;
        end else begin
            wr_en <= 1'b0;
            if (init) begin
                ptr  <= '0;
                sum  <= 8'h00;
                tok  <= 8'h00;
                has  <= 1'b0;
                acc  <= '0;
                bcnt <= 3'd0;
            end else if (stb || flush) begin
                if (!b64) begin
                    if (stb && is_hex(ch)) begin
                        tok <= {tok[3:0], hex_val(ch)};
                        has <= 1'b1;
                    end else if (has) begin
                        wr_en   <= 1'b1;
                        wr_data <= tok;
                        wr_addr <= ptr;
                        ptr     <= ptr + 1'b1;
                        sum     <= sum + tok;
                        has     <= 1'b0;
                        tok     <= 8'h00;
                    end
                end else if (stb && is_b64(ch)) begin
                    acc <= acc_nx;
                    if (c >= 4'd8) begin
                        wr_en   <= 1'b1;
                        wr_data <= shifted[7:0];
                        wr_addr <= ptr;
                        ptr     <= ptr + 1'b1;
                        sum     <= sum + shifted[7:0];
                        bcnt    <= 3'(c - 4'd8);
                    end else begin
                        bcnt <= c[2:0];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/boot_reply.sv
// Reply sender: emits the identity string or a single pass/fail byte over a
// ready/valid transmit port, then pulses done for one cycle.
// Assumes start is not raised while a reply is pending.
module boot_reply
    import boot_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  rep_e       kind,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       done
);
    localparam logic [2:0] ID_LAST = 3'(ID_LEN - 1);

    rep_e       kind_q;
    logic [2:0] idx;
    logic       last;

    assign last = (kind_q == REP_ID) ? (idx == ID_LAST) : 1'b1;

    // Select the byte on offer
    always_comb begin
        case (kind_q)
            REP_ID:   tx_data = id_char(idx);
            REP_PASS: tx_data = CH_PASS;
            default:  tx_data = CH_FAIL;
        endcase
    end

    // Step through the reply on each handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            kind_q   <= REP_ID;
            idx      <= 3'd0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                tx_valid <= 1'b1;
                kind_q   <= kind;
                idx      <= 3'd0;
            end else if (tx_valid && tx_ready) begin
                if (last) begin
                    tx_valid <= 1'b0;
                    done     <= 1'b1;
                end else begin
                    idx <= idx + 3'd1;
                end
            end
        end
    end
endmodule

// File: rtl/boot_cmd_parser.sv
// Serial boot command parser top: keyword search, argument capture with pin
// qualification, payload decode, checksum decision, reply and run pulse.
// Assumes one byte per rx handshake; rx_ready drops only while replying.
module boot_cmd_parser
    import boot_cmd_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PIN_W  = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic [PIN_W-1:0]  pins_a,
    input  logic [PIN_W-1:0]  pins_b,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              run
);
    typedef enum logic [1:0] {ST_KEY, ST_ARG, ST_DATA, ST_REPLY} st_e;

    st_e             state;
    cmd_e            cmd_q, key_cmd;
    logic [PIN_W-1:0] am, ad, bm, tok;
    logic            tok_has, run_after, run_req;
    logic [1:0]      argi;
    logic            acc, is_sync, is_term, pins_ok, key_hit, key_stb;
    logic            pay_init, pay_stb, pay_flush, pay_bad;
    logic [7:0]      sum_after;
    logic            rep_start, rep_done;
    rep_e            rep_kind;

    assign rx_ready = (state != ST_REPLY);
    assign acc      = rx_valid && rx_ready;
    assign is_sync  = acc && (rx_data == CH_SYNC);
    assign is_term  = (rx_data == CH_CHECKED) || (rx_data == CH_DIRECT);
    assign pins_ok  = ((pins_a & am) == ad) && ((pins_b & bm) == tok);
    assign key_stb  = acc && (state == ST_KEY) && !is_sync;

    // Decide the strobes to the payload decoder and the reply sender
    always_comb begin
        pay_init  = 1'b0;
        pay_stb   = 1'b0;
        pay_flush = 1'b0;
        rep_start = 1'b0;
        rep_kind  = REP_ID;
        case (state)
            ST_ARG: if (acc && !is_sync && is_sep(rx_data) && tok_has &&
                        argi == 2'd3 && pins_ok) begin
                if (cmd_q == CMD_QRY) rep_start = 1'b1;
                else                  pay_init  = 1'b1;
            end
            ST_DATA: if (acc && !is_sync) begin
                if (is_term) begin
                    pay_flush = 1'b1;
                    if (rx_data == CH_CHECKED) begin
                        rep_start = 1'b1;
                        rep_kind  = (sum_after == 8'h00) ? REP_PASS : REP_FAIL;
                    end
                end else if (!pay_bad) begin
                    pay_stb = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Command state, argument capture and run sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_KEY;
            cmd_q     <= CMD_QRY;
            am        <= '0;
            ad        <= '0;
            bm        <= '0;
            tok       <= '0;
            tok_has   <= 1'b0;
            argi      <= 2'd0;
            run_after <= 1'b0;
            run_req   <= 1'b0;
            run       <= 1'b0;
        end else begin
            run_req <= 1'b0;
            run     <= run_req;
            if (is_sync) begin
                state <= ST_KEY;
            end else begin
                case (state)
                    ST_KEY: if (key_hit) begin
                        state   <= ST_ARG;
                        cmd_q   <= key_cmd;
                        argi    <= 2'd0;
                        tok     <= '0;
                        tok_has <= 1'b0;
                    end
                    ST_ARG: if (acc) begin
                        if (is_hex(rx_data)) begin
                            tok     <= {tok[PIN_W-5:0], hex_val(rx_data)};
                            tok_has <= 1'b1;
                        end else if (is_sep(rx_data)) begin
                            if (tok_has) begin
                                tok_has <= 1'b0;
                                tok     <= '0;
                                argi    <= argi + 2'd1;
                                case (argi)
                                    2'd0: am <= tok;
                                    2'd1: ad <= tok;
                                    2'd2: bm <= tok;
                                    default: begin
                                        run_after <= 1'b0;
                                        if (!pins_ok)             state <= ST_KEY;
                                        else if (cmd_q == CMD_QRY) state <= ST_REPLY;
                                        else                      state <= ST_DATA;
                                    end
                                endcase
                            end
                        end else begin
                            state <= ST_KEY;
                        end
                    end
                    ST_DATA: if (acc) begin
                        if (is_term) begin
                            if (rx_data == CH_CHECKED) begin
                                state     <= ST_REPLY;
                                run_after <= (sum_after == 8'h00);
                            end else begin
                                state   <= ST_KEY;
                                run_req <= 1'b1;
                            end
                        end else if (pay_bad) begin
                            state <= ST_KEY;
                        end
                    end
                    default: if (rep_done) begin
                        state   <= ST_KEY;
                        run_req <= run_after;
                    end
                endcase
            end
        end
    end

    boot_key_match u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (is_sync),
        .stb   (key_stb),
        .ch    (rx_data),
        .hit   (key_hit),
        .cmd   (key_cmd)
    );

    boot_payload #(.ADDR_W(ADDR_W)) u_pay (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (pay_init),
        .stb       (pay_stb),
        .flush     (pay_flush),
        .b64       (cmd_q == CMD_B64),
        .ch        (rx_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sum_after (sum_after),
        .bad       (pay_bad)
    );

    boot_reply u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (rep_start),
        .kind     (rep_kind),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .done     (rep_done)
    );
endmodule

// File: rtl/boot_cmd_parser_chk.sv
// Port-level checker for boot_cmd_parser, attached by bind below.
module boot_cmd_parser_chk #(
    parameter int ADDR_W = 10
)(
    input logic              clk,
    input logic              rst_n,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              run
);
    // R12: run lasts one cycle
    p_run_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> !run);

    // R11: a stalled reply byte is held
    p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R11: no input taken while replying
    p_rx_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);

    // R5: back-to-back writes step the address by one
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

    // R7: execution starts only once no reply is pending
    p_run_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !tx_valid);
endmodule

bind boot_cmd_parser boot_cmd_parser_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/boot_cmd_parser_bench.sv
// Directed bench for boot_cmd_parser: one task per scenario.
module boot_cmd_parser_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10;
    localparam int PIN_W  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic rx_ready;
    logic tx_valid;
    logic [7:0] tx_data;
    logic tx_ready = 1'b1;
    logic [PIN_W-1:0] pins_a = '0;
    logic [PIN_W-1:0] pins_b = '0;
    logic wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0] wr_data;
    logic run;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0]        txlog [0:127];
    int                txn = 0;
    logic [7:0]        wdat  [0:63];
    logic [ADDR_W-1:0] wadr  [0:63];
    int                wn = 0;
    int                runn = 0;
    int                wide = 0;
    logic              run_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_cmd_parser #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_boot_cmd_parser (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .pins_a(pins_a), .pins_b(pins_b), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .run(run)
    );

    // Record transmitted bytes, writes and run pulses
    always @(posedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                txlog[txn % 128] <= tx_data;
                txn <= txn + 1;
            end
            if (wr_en) begin
                wdat[wn % 64] <= wr_data;
                wadr[wn % 64] <= wr_addr;
                wn <= wn + 1;
            end
            if (run) begin
                runn <= runn + 1;
                if (run_prev) wide <= wide + 1;
            end
            run_prev <= run;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_char(input logic [7:0] c);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = c;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_char(s[i]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_tx(input string req, input string s, input int base);
        check(txn - base == s.len(), req, "reply length", txn - base, s.len());
        for (int i = 0; i < s.len() && i < txn - base; i++)
            check(txlog[(base + i) % 128] == s[i], req, "reply byte",
                  txlog[(base + i) % 128], s[i]);
    endtask

    task automatic expect_wr(input string req, input int base, input int k,
                             input logic [7:0] d);
        check(wadr[(base + k) % 64] == ADDR_W'(k), req, "write address",
              wadr[(base + k) % 64], k);
        check(wdat[(base + k) % 64] == d, req, "write data",
              wdat[(base + k) % 64], d);
    endtask

    task automatic t_reset;
        check(rx_ready == 1'b1, "R1", "rx_ready", rx_ready, 1);
        check(tx_valid == 1'b0, "R1", "tx_valid", tx_valid, 0);
        check(wr_en == 1'b0, "R1", "wr_en", wr_en, 0);
        check(run == 1'b0, "R1", "run", run, 0);
    endtask

    task automatic t_query_pass;
        int tb = txn, wb = wn;
        pins_a = 32'h0000_005A;
        send_str(">Boot_Qry FF 5A 0 0 ");
        idle(20);
        expect_tx("R4", "SBC1\015\012", tb);
        check(wn == wb, "R4", "no writes on query", wn - wb, 0);
    endtask

    task automatic t_query_fail;
        int tb = txn;
        pins_a = 32'h0000_005B;
        send_str(">Boot_Qry FF 5A 0 0 ");
        idle(20);
        check(txn == tb, "R3", "masked-out query silent", txn - tb, 0);
        pins_a = '0;
    endtask

    task automatic t_hex_checked_pass;
        int tb = txn, wb = wn, rb = runn;
        send_str(">Boot_Hex 0 0 0 0 12 34 BA?");
        idle(20);
        check(wn - wb == 3, "R5", "write count", wn - wb, 3);
        expect_wr("R5", wb, 0, 8'h12);
        expect_wr("R5", wb, 1, 8'h34);
        expect_wr("R5", wb, 2, 8'hBA);
        expect_tx("R8", ".", tb);
        check(runn - rb == 1, "R8", "run after pass", runn - rb, 1);
    endtask

    task automatic t_hex_direct;
        int tb = txn, wb = wn, rb = runn;
        send_str(">Boot_Hex 0 0 0 0 1 AB3 ~");
        idle(20);
        check(wn - wb == 2, "R5", "write count", wn - wb, 2);
        expect_wr("R5", wb, 0, 8'h01);
        expect_wr("R5", wb, 1, 8'hB3);
        check(txn == tb, "R7", "no reply", txn - tb, 0);
        check(runn - rb == 1, "R7", "run pulse", runn - rb, 1);
    endtask

    task automatic t_hex_checked_fail;
        int tb = txn, rb = runn;
        send_str(">Boot_Hex 0 0 0 0 01 02?");
        idle(20);
        expect_tx("R9", "!", tb);
        check(runn == rb, "R9", "no run on fail", runn - rb, 0);
        tb = txn;
        send_str("Boot_Qry 0 0 0 0 ");
        idle(20);
        expect_tx("R9", "SBC1\015\012", tb);
    endtask

    task automatic t_b64_quad;
        int wb = wn, rb = runn;
        send_str(">Boot_B64 0 0 0 0 TWFu ~");
        idle(20);
        check(wn - wb == 3, "R6", "write count", wn - wb, 3);
        expect_wr("R6", wb, 0, 8'h4D);
        expect_wr("R6", wb, 1, 8'h61);
        expect_wr("R6", wb, 2, 8'h6E);
        check(runn - rb == 1, "R7", "run pulse", runn - rb, 1);
    endtask

    task automatic t_b64_pad;
        int wb = wn;
        send_str(">Boot_B64 0 0 0 0 TW E= ~");
        idle(20);
        check(wn - wb == 2, "R6", "padded write count", wn - wb, 2);
        expect_wr("R6", wb, 0, 8'h4D);
        expect_wr("R6", wb, 1, 8'h61);
    endtask

    task automatic t_b64_checked;
        int tb = txn, wb = wn, rb = runn;
        send_str(">Boot_B64 0 0 0 0 AAAA?");
        idle(20);
        check(wn - wb == 3, "R6", "zero quad writes", wn - wb, 3);
        expect_wr("R6", wb, 2, 8'h00);
        expect_tx("R8", ".", tb);
        check(runn - rb == 1, "R8", "run after pass", runn - rb, 1);
    endtask

    task automatic t_load_mask_fail;
        int tb = txn, wb = wn, rb = runn;
        pins_b = 32'h3;
        send_str(">Boot_Hex 0 0 F 1 55 ~");
        idle(20);
        check(wn == wb, "R3", "no writes", wn - wb, 0);
        check(runn == rb, "R3", "no run", runn - rb, 0);
        check(txn == tb, "R3", "no reply", txn - tb, 0);
        pins_b = '0;
    endtask

    task automatic t_abort;
        int tb = txn, wb = wn, rb = runn;
        send_str(">Boot_Hex 0 0 0 0 12 G3 ~");
        idle(20);
        check(wn - wb == 1, "R10", "writes before abort", wn - wb, 1);
        check(runn == rb, "R10", "no run after abort", runn - rb, 0);
        send_str(">Boot_Qry 0 0 Z 0 0 ");
        idle(20);
        check(txn == tb, "R10", "no reply after abort", txn - tb, 0);
    endtask

    task automatic t_sync;
        int tb = txn;
        send_str("Boot_Hex 0 0 >Boot_Qry 0 0 0 0 ");
        idle(20);
        expect_tx("R2", "SBC1\015\012", tb);
        tb = txn;
        send_str("BBoot_Qry 0 0 0 0 ");
        idle(20);
        expect_tx("R2", "SBC1\015\012", tb);
    endtask

    task automatic t_stall;
        int tb = txn;
        tx_ready = 1'b0;
        send_str(">Boot_Qry 0 0 0 0 ");
        idle(6);
        check(tx_valid == 1'b1, "R11", "reply pending", tx_valid, 1);
        check(tx_data == 8'h53, "R11", "held byte", tx_data, 8'h53);
        check(rx_ready == 1'b0, "R11", "input blocked", rx_ready, 0);
        idle(3);
        check(tx_data == 8'h53, "R11", "byte still held", tx_data, 8'h53);
        tx_ready = 1'b1;
        idle(20);
        expect_tx("R11", "SBC1\015\012", tb);
        check(rx_ready == 1'b1, "R11", "input reopened", rx_ready, 1);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_query_pass();
        t_query_fail();
        t_hex_checked_pass();
        t_hex_direct();
        t_hex_checked_fail();
        t_b64_quad();
        t_b64_pad();
        t_b64_checked();
        t_load_mask_fail();
        t_abort();
        t_sync();
        t_stall();
        check(wide == 0, "R12", "run pulses wider than one cycle", wide, 0);
        check(runn == 5, "R12", "total run pulses", runn, 5);
        finish_run();
    end
endmodule